// File: doc/BRIEF.md
# Hardware Stack and Call/Return Sequencer

This block holds the stack pointer, the frame base pointer and the instruction pointer of a small processor core. It executes one stack command at a time against a synchronous data memory port with one cycle of read latency. The command set is push, pop, call, return, return-with-release, frame entry, frame exit and jump. The stack grows toward lower addresses. A write always follows the pointer decrement. A read always comes before the pointer increment. Return addresses are moved through the stack as 8-byte words.

A command is offered with `cmd_valid` while `busy` is low and is taken on that clock edge. The unit then makes at most one memory access and pulses `done` for one cycle. `done` comes with the final pointer values and the alignment flag. The sequencer uses five states: IDLE, WRITE, READ, CAPTURE and FINISH. The transitions are:
- IDLE to WRITE on push, call or frame entry.
- IDLE to READ on pop, return, return-with-release or frame exit.
- IDLE to FINISH on jump.
- WRITE to FINISH.
- READ to CAPTURE.
- CAPTURE to FINISH.
- FINISH to IDLE.

Top module: `stack_call_unit`

## Requirements
- R1: Push (`cmd_op`=0) lowers `sp` by the operand size in the cycle after acceptance. It then writes the operand, masked to that size, at the new `sp`.
- R2: Pop (`cmd_op`=1) reads at the current `sp`, then raises `sp` by the operand size. `pop_data` holds the read value, zero-extended.
- R3: `cmd_size` is used only by push and pop: 0 selects 2 bytes, 1 selects 4 bytes, and 2 or 3 select 8 bytes. Memory is little-endian. `mem_size` carries the same code.
- R4: Call (`cmd_op`=2) lowers `sp` by 8 and writes `ip + cmd_len` there as an 8-byte word. It then loads `ip` with `cmd_data`.
- R5: Return (`cmd_op`=3) reads the 8-byte word at `sp` into `ip` and raises `sp` by 8.
- R6: Return-with-release (`cmd_op`=4) behaves as R5 and additionally adds `cmd_imm` bytes to `sp`.
- R7: Frame entry (`cmd_op`=5) pushes `bp` as an 8-byte word, then copies the new `sp` into `bp`.
- R8: Frame exit (`cmd_op`=6) copies `bp` into `sp`, then pops the 8-byte word there into `bp`.
- R9: Jump (`cmd_op`=7) loads `ip` with `cmd_data` and makes no memory access. `ip` changes only by call, return, return-with-release, jump or reset.
- R10: Each command makes exactly one memory access, except jump, which makes none. `done` rises 2 cycles after acceptance for write commands, 3 cycles after for read commands and 1 cycle after for jump, and lasts one cycle. Commands offered while `busy` is high are ignored.
- R11: `align_err` is high together with `done` when the final `sp` is not a multiple of the command's operand size. That size is 8 for every command other than push and pop.
- R12: Reset sets `sp` and `bp` to `SP_INIT` and `ip` to `IP_INIT`, and clears `busy`, `done` and `pop_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 3 | Command code |
| cmd_size | input | 2 | Operand size code for push and pop |
| cmd_data | input | 64 | Push operand, or call/jump target |
| cmd_len | input | LEN_W | Length of the current instruction, used by call |
| cmd_imm | input | IMM_W | Bytes released by return-with-release |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| align_err | output | 1 | Stack pointer misaligned at completion |
| pop_data | output | 64 | Last popped value |
| sp | output | AW | Stack pointer |
| bp | output | AW | Frame base pointer |
| ip | output | AW | Instruction pointer |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write enable |
| mem_size | output | 2 | Access size code |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, one cycle after the request |

## Verification
Pushes of 2, 4 and 8 bytes, followed by pops in reverse order, show whether each size is decremented, masked and placed correctly. Only a correct order of write and decrement returns the original values. A nested call with frame entry, local pushes, frame exit and return shows whether `bp` and the return address survive the stack traffic. A call that leaves `sp` at an odd multiple of 4, followed by return-with-release, separates the release arithmetic from the alignment flag. Per-command latency and access counts, together with a jump held on the inputs while busy, show whether commands are accepted only when the unit is idle.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        OP_PUSH  = 3'd0,
        OP_POP   = 3'd1,
        OP_CALL  = 3'd2,
        OP_RET   = 3'd3,
        OP_RETN  = 3'd4,
        OP_ENTER = 3'd5,
        OP_LEAVE = 3'd6,
        OP_JUMP  = 3'd7
    } stk_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR,
        S_RD,
        S_CAP,
        S_DONE
    } stk_state_e;

    // size code used for every pointer-sized stack word
    localparam logic [1:0] PTR_SZ = 2'b10;

endpackage

// File: rtl/stk_size_dec.sv
module stk_size_dec #(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic [1:0]    size_code,
    output logic [AW-1:0] nbytes,
    output logic [DW-1:0] dmask
);
    localparam int NB = DW / 8;

    int unsigned n_int;

    always_comb begin
        unique case (size_code)
            2'b00:   n_int = 2;
            2'b01:   n_int = 4;
            default: n_int = 8;
        endcase
    end

    assign nbytes = AW'(n_int);

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign dmask[b*8 +: 8] = (b < n_int) ? 8'hFF : 8'h00;
    end

endmodule

// File: rtl/stk_ptr_file.sv
module stk_ptr_file #(
    parameter int          AW      = 32,
    parameter logic [31:0] SP_INIT = 32'h0000_8000,
    parameter logic [31:0] IP_INIT = 32'h0000_0400
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sp_ld,
    input  logic [AW-1:0] sp_nxt,
    input  logic          bp_ld,
    input  logic [AW-1:0] bp_nxt,
    input  logic          ip_ld,
    input  logic [AW-1:0] ip_nxt,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] bp,
    output logic [AW-1:0] ip
);
    localparam int NREG = 3;

    logic [NREG-1:0] ld;
    logic [AW-1:0]   nxt [NREG];
    logic [AW-1:0]   cur [NREG];

    assign ld     = {ip_ld, bp_ld, sp_ld};
    assign nxt[0] = sp_nxt;
    assign nxt[1] = bp_nxt;
    assign nxt[2] = ip_nxt;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [AW-1:0] RST = (g == 2) ? AW'(IP_INIT) : AW'(SP_INIT);
        logic [AW-1:0] r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     r <= RST;
            else if (ld[g]) r <= nxt[g];
        end
        assign cur[g] = r;
    end

    assign sp = cur[0];
    assign bp = cur[1];
    assign ip = cur[2];

endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 64,
    parameter int LEN_W = 4,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [1:0]       cmd_size,
    input  logic [DW-1:0]    cmd_data,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [IMM_W-1:0] cmd_imm,
    input  logic [AW-1:0]    sp_i,
    input  logic [AW-1:0]    bp_i,
    input  logic [AW-1:0]    ip_i,
    output logic             sp_ld,
    output logic [AW-1:0]    sp_nxt,
    output logic             bp_ld,
    output logic [AW-1:0]    bp_nxt,
    output logic             ip_ld,
    output logic [AW-1:0]    ip_nxt,
    output logic             mem_req,
    output logic             mem_we,
    output logic [1:0]       mem_size,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic             busy,
    output logic             done,
    output logic             align_err,
    output logic [DW-1:0]    pop_data
);
    stk_state_e       state_q, state_d;
    stk_op_e          op_q;
    logic [1:0]       szc_q;
    logic [IMM_W-1:0] imm_q;
    logic [AW-1:0]    tgt_q;
    logic [DW-1:0]    wdata_q;
    logic [DW-1:0]    pop_q;

    stk_op_e          op_in;
    logic [1:0]       sz_in;
    logic [AW-1:0]    nb_a, nb_b, rel_b;
    logic [DW-1:0]    mask_a, mask_b;
    logic             accept;

    assign op_in  = stk_op_e'(cmd_op);
    assign sz_in  = (op_in == OP_PUSH || op_in == OP_POP) ? cmd_size : PTR_SZ;
    assign accept = cmd_valid && (state_q == S_IDLE);
    assign rel_b  = (op_q == OP_RETN) ? AW'(imm_q) : '0;

    stk_size_dec #(.AW(AW), .DW(DW)) u_dec_in (
        .size_code (sz_in),
        .nbytes    (nb_a),
        .dmask     (mask_a)
    );

    stk_size_dec #(.AW(AW), .DW(DW)) u_dec_cur (
        .size_code (szc_q),
        .nbytes    (nb_b),
        .dmask     (mask_b)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    unique case (op_in)
                        OP_PUSH, OP_CALL, OP_ENTER:          state_d = S_WR;
                        OP_POP, OP_RET, OP_RETN, OP_LEAVE:   state_d = S_RD;
                        OP_JUMP:                             state_d = S_DONE;
                        default:                             state_d = S_IDLE;
                    endcase
                end
            end
            S_WR:    state_d = S_DONE;
            S_RD:    state_d = S_CAP;
            S_CAP:   state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // command capture and pop result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_PUSH;
            szc_q   <= PTR_SZ;
            imm_q   <= '0;
            tgt_q   <= '0;
            wdata_q <= '0;
            pop_q   <= '0;
        end else begin
            if (accept) begin
                op_q  <= op_in;
                szc_q <= sz_in;
                imm_q <= cmd_imm;
                tgt_q <= cmd_data[AW-1:0];
                unique case (op_in)
                    OP_PUSH:  wdata_q <= cmd_data & mask_a;
                    OP_CALL:  wdata_q <= DW'(ip_i + AW'(cmd_len));
                    OP_ENTER: wdata_q <= DW'(bp_i);
                    default:  wdata_q <= '0;
                endcase
            end
            if (state_q == S_CAP && op_q == OP_POP) begin
                pop_q <= mem_rdata & mask_b;
            end
        end
    end

    // outputs
    always_comb begin
        sp_ld     = 1'b0;
        sp_nxt    = sp_i;
        bp_ld     = 1'b0;
        bp_nxt    = bp_i;
        ip_ld     = 1'b0;
        ip_nxt    = ip_i;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_size  = szc_q;
        mem_addr  = sp_i;
        mem_wdata = wdata_q;
        done      = 1'b0;
        align_err = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    unique case (op_in)
                        OP_PUSH, OP_CALL, OP_ENTER: begin
                            sp_ld  = 1'b1;
                            sp_nxt = sp_i - nb_a;
                        end
                        OP_LEAVE: begin
                            sp_ld  = 1'b1;
                            sp_nxt = bp_i;
                        end
                        OP_JUMP: begin
                            ip_ld  = 1'b1;
                            ip_nxt = cmd_data[AW-1:0];
                        end
                        default: ;
                    endcase
                end
            end
            S_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (op_q == OP_CALL) begin
                    ip_ld  = 1'b1;
                    ip_nxt = tgt_q;
                end
                if (op_q == OP_ENTER) begin
                    bp_ld  = 1'b1;
                    bp_nxt = sp_i;
                end
            end
            S_RD: begin
                mem_req = 1'b1;
            end
            S_CAP: begin
                sp_ld  = 1'b1;
                sp_nxt = sp_i + nb_b + rel_b;
                if (op_q == OP_RET || op_q == OP_RETN) begin
                    ip_ld  = 1'b1;
                    ip_nxt = mem_rdata[AW-1:0];
                end
                if (op_q == OP_LEAVE) begin
                    bp_ld  = 1'b1;
                    bp_nxt = mem_rdata[AW-1:0];
                end
            end
            S_DONE: begin
                done      = 1'b1;
                align_err = (sp_i & (nb_b - AW'(1))) != '0;
            end
            default: ;
        endcase
    end

    assign busy     = (state_q != S_IDLE);
    assign pop_data = pop_q;

    AST_PUSH_PREDEC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WR) |-> (($past(sp_i) - sp_i) == nb_b)); // R1

    AST_POP_POSTINC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CAP) |=> ((sp_i - $past(sp_i)) == $past(nb_b + rel_b))); // R6

    AST_IP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_WR || state_q == S_CAP) &&
         !(op_q == OP_CALL || op_q == OP_RET || op_q == OP_RETN)) |=> $stable(ip_i)); // R9

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

endmodule

// File: rtl/stack_call_unit.sv
module stack_call_unit #(
    parameter int          AW      = 32,
    parameter int          LEN_W   = 4,
    parameter int          IMM_W   = 16,
    parameter logic [31:0] SP_INIT = 32'h0000_8000,
    parameter logic [31:0] IP_INIT = 32'h0000_0400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [1:0]       cmd_size,
    input  logic [63:0]      cmd_data,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [IMM_W-1:0] cmd_imm,
    output logic             busy,
    output logic             done,
    output logic             align_err,
    output logic [63:0]      pop_data,
    output logic [AW-1:0]    sp,
    output logic [AW-1:0]    bp,
    output logic [AW-1:0]    ip,
    output logic             mem_req,
    output logic             mem_we,
    output logic [1:0]       mem_size,
    output logic [AW-1:0]    mem_addr,
    output logic [63:0]      mem_wdata,
    input  logic [63:0]      mem_rdata
);
    localparam int DW = 64;

    logic          sp_ld, bp_ld, ip_ld;
    logic [AW-1:0] sp_nxt, bp_nxt, ip_nxt;

    stk_ptr_file #(
        .AW      (AW),
        .SP_INIT (SP_INIT),
        .IP_INIT (IP_INIT)
    ) u_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .sp_ld  (sp_ld),
        .sp_nxt (sp_nxt),
        .bp_ld  (bp_ld),
        .bp_nxt (bp_nxt),
        .ip_ld  (ip_ld),
        .ip_nxt (ip_nxt),
        .sp     (sp),
        .bp     (bp),
        .ip     (ip)
    );

    stk_seq #(
        .AW    (AW),
        .DW    (DW),
        .LEN_W (LEN_W),
        .IMM_W (IMM_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_size  (cmd_size),
        .cmd_data  (cmd_data),
        .cmd_len   (cmd_len),
        .cmd_imm   (cmd_imm),
        .sp_i      (sp),
        .bp_i      (bp),
        .ip_i      (ip),
        .sp_ld     (sp_ld),
        .sp_nxt    (sp_nxt),
        .bp_ld     (bp_ld),
        .bp_nxt    (bp_nxt),
        .ip_ld     (ip_ld),
        .ip_nxt    (ip_nxt),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_size  (mem_size),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .done      (done),
        .align_err (align_err),
        .pop_data  (pop_data)
    );

endmodule

// File: tb/test_stack_call_unit.sv
module test_stack_call_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [1:0]  cmd_size = '0;
    logic [63:0] cmd_data = '0;
    logic [3:0]  cmd_len = '0;
    logic [15:0] cmd_imm = '0;
    logic        busy, done, align_err;
    logic [63:0] pop_data;
    logic [31:0] sp, bp, ip;
    logic        mem_req, mem_we;
    logic [1:0]  mem_size;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stack_call_unit i_stack_call_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_size(cmd_size), .cmd_data(cmd_data), .cmd_len(cmd_len),
        .cmd_imm(cmd_imm), .busy(busy), .done(done), .align_err(align_err),
        .pop_data(pop_data), .sp(sp), .bp(bp), .ip(ip), .mem_req(mem_req),
        .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // byte-addressed little-endian memory, one cycle read latency
    logic [7:0] mem [256];

    function automatic int nbytes_of(input logic [1:0] c);
        return (c == 2'd0) ? 2 : (c == 2'd1) ? 4 : 8;
    endfunction

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < nbytes_of(mem_size); b++)
                    mem[8'(mem_addr + 32'(b))] <= mem_wdata[b*8 +: 8];
            end else begin
                logic [63:0] rd;
                rd = '0;
                for (int b = 0; b < 8; b++)
                    rd[b*8 +: 8] = mem[8'(mem_addr + 32'(b))];
                mem_rdata <= rd;
            end
        end
    end

    // op codes: 0 push,1 pop,2 call,3 ret,4 ret+release,5 enter,6 leave,7 jump
    localparam logic [2:0]  V_OP  [NV] = '{0,0,0,1,1,1,2,5,0,0,6,3,0,2,4,7};
    localparam logic [1:0]  V_SZ  [NV] = '{1,0,2,2,0,1,0,0,2,3,0,0,1,0,0,0};
    localparam logic [63:0] V_DAT [NV] = '{
        64'hDEAD_BEEF_CAFE_F00D, 64'h1234_5678, 64'h1122_3344_5566_7788, 0, 0, 0,
        64'h2000, 0, 64'hAAAA_BBBB_CCCC_DDDD, 64'h0102_0304_0506_0708, 0, 0,
        64'h77, 64'h3000, 0, 64'h5000};
    localparam logic [3:0]  V_LEN [NV] = '{0,0,0,0,0,0,5,0,0,0,0,0,0,3,0,0};
    localparam logic [15:0] V_IMM [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,0,0,4,0};
    localparam logic [31:0] E_SP  [NV] = '{
        32'h7FFC, 32'h7FFA, 32'h7FF2, 32'h7FFA, 32'h7FFC, 32'h8000, 32'h7FF8, 32'h7FF0,
        32'h7FE8, 32'h7FE0, 32'h7FF8, 32'h8000, 32'h7FFC, 32'h7FF4, 32'h8000, 32'h8000};
    localparam logic [31:0] E_BP  [NV] = '{
        32'h8000, 32'h8000, 32'h8000, 32'h8000, 32'h8000, 32'h8000, 32'h8000, 32'h7FF0,
        32'h7FF0, 32'h7FF0, 32'h8000, 32'h8000, 32'h8000, 32'h8000, 32'h8000, 32'h8000};
    localparam logic [31:0] E_IP  [NV] = '{
        32'h400, 32'h400, 32'h400, 32'h400, 32'h400, 32'h400, 32'h2000, 32'h2000,
        32'h2000, 32'h2000, 32'h2000, 32'h405, 32'h405, 32'h3000, 32'h408, 32'h5000};
    localparam logic [63:0] E_POP [NV] = '{
        0, 0, 0, 64'h1122_3344_5566_7788, 64'h5678, 64'hCAFE_F00D,
        64'hCAFE_F00D, 64'hCAFE_F00D, 64'hCAFE_F00D, 64'hCAFE_F00D, 64'hCAFE_F00D,
        64'hCAFE_F00D, 64'hCAFE_F00D, 64'hCAFE_F00D, 64'hCAFE_F00D, 64'hCAFE_F00D};
    localparam logic        E_AL  [NV] = '{0,0,1,1,0,0,0,0,0,0,0,0,0,1,0,0};
    localparam int          E_LAT [NV] = '{2,2,2,3,3,3,2,2,2,2,3,3,2,2,3,1};

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0:    return "R1/R3";
            3'd1:    return "R2/R3";
            3'd2:    return "R4";
            3'd3:    return "R5";
            3'd4:    return "R6";
            3'd5:    return "R7";
            3'd6:    return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [1:0] sz,
                           input logic [63:0] dat, input logic [3:0] len,
                           input logic [15:0] imm, output int lat, output int nacc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_size = sz;
        cmd_data = dat; cmd_len = len; cmd_imm = imm;
        lat = 0; nacc = 0;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 1;
        if (mem_req) nacc++;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
            if (mem_req) nacc++;
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12", "sp", 64'(sp), 64'h8000);
        check("R12", "bp", 64'(bp), 64'h8000);
        check("R12", "ip", 64'(ip), 64'h400);
        check("R12", "busy/done", {62'd0, busy, done}, 64'd0);
        check("R12", "pop_data", pop_data, 64'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            int lat, nacc;
            run_cmd(V_OP[v], V_SZ[v], V_DAT[v], V_LEN[v], V_IMM[v], lat, nacc);
            check(tag_of(V_OP[v]), "sp", 64'(sp), 64'(E_SP[v]));
            check(tag_of(V_OP[v]), "bp", 64'(bp), 64'(E_BP[v]));
            check(tag_of(V_OP[v]), "ip", 64'(ip), 64'(E_IP[v]));
            check(tag_of(V_OP[v]), "pop_data", pop_data, E_POP[v]);
            check("R11", "align_err", 64'(align_err), 64'(E_AL[v]));
            check("R10", "latency", 64'(lat), 64'(E_LAT[v]));
            check("R10", "accesses", 64'((V_OP[v] == 3'd7) ? 0 : 1), 64'(nacc));
            @(negedge clk);
            check("R10", "done width", 64'(done), 64'd0);
        end

        // R10: a jump held on the inputs while busy must be ignored
        begin
            int lat;
            @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 3'd0; cmd_size = 2'd2; cmd_data = 64'h55;
            @(negedge clk);
            cmd_op = 3'd7; cmd_data = 64'h9999;
            lat = 1;
            while (!done && lat < 20) begin
                @(negedge clk);
                lat++;
            end
            cmd_valid = 1'b0;
            @(negedge clk);
            @(negedge clk);
            check("R10", "ip after busy jump", 64'(ip), 64'h5000);
            check("R10", "sp after busy jump", 64'(sp), 64'h7FF8);
            check("R10", "idle after", 64'(busy), 64'd0);
        end

        // R9/R3: pop of 8 bytes leaves ip unchanged
        begin
            int lat, nacc;
            run_cmd(3'd1, 2'd2, 64'd0, 4'd0, 16'd0, lat, nacc);
            check("R9", "ip after pop", 64'(ip), 64'h5000);
            check("R3", "pop 8B", pop_data, 64'h55);
        end

        // R12: reset in the middle of a command
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd2; cmd_data = 64'h7000;
        @(negedge clk);
        cmd_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R12", "sp after reset", 64'(sp), 64'h8000);
        check("R12", "ip after reset", 64'(ip), 64'h400);
        check("R12", "busy after reset", 64'(busy), 64'd0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule